// File: doc/BRIEF.md
# Wavefront Row/Bank Data Sharing Unit

This block is the cross-lane operand fetch stage of a 64-lane vector datapath. The lanes are organised as four rows of sixteen, and each row is split into four banks of four consecutive lanes. For every destination lane, a 9-bit control code picks a source lane. The block then applies a per-row enable mask, a per-bank enable mask and a boundary policy for lanes whose computed source does not exist. It produces a registered result vector and a per-lane write-enable.

A request is presented with `in_valid` together with the source vector, the old destination vector, the control code, both masks and the boundary flag. Exactly one cycle later the result appears with `out_valid`. A small output state machine has three states. `ST_IDLE` means no result. `ST_DONE` means a legal result is present. `ST_FAULT` means the last request carried an undefined code. The transitions are: `GO_DONE` on a valid legal request, `GO_FAULT` on a valid illegal request, and `GO_IDLE` when `in_valid` is low. Every state can take every transition.

Top module: `wave_share_unit`

## Requirements
- R1: When ctrl[8]=0 the code is a quad permute. Destination lane L takes lane 4*(L/4)+s, where s = ctrl[2*(L%4)+1 : 2*(L%4)]. The source is always valid.
- R2: Row shift. Codes 0x101..0x10F give lane L the source L+n, where n = ctrl[3:0]. Codes 0x111..0x11F give lane L the source L-n. In both cases the source is invalid when it leaves L's 16-lane row.
- R3: Row rotate right. Codes 0x121..0x12F give lane L the source 16*(L/16) + ((L%16 - n) mod 16), where n = ctrl[3:0]. The source is always valid.
- R4: Whole-wave moves by one lane. 0x130 is shift (source L+1, invalid for lane 63). 0x134 is rotate (source (L+1) mod 64). 0x138 is shift (source L-1, invalid for lane 0). 0x13C is rotate (source (L-1) mod 64).
- R5: 0x140 mirrors within a row (source 16*(L/16)+15-L%16). 0x141 mirrors within each 8-lane half row (source 8*(L/8)+7-L%8).
- R6: 0x142 gives rows 1..3 the last lane of the previous row (source 16*(L/16)-1); for row 0 the source is invalid. 0x143 gives rows 2 and 3 lane 31; for rows 0 and 1 the source is invalid.
- R7: Lane L is eligible for writing only if row_mask[L/16] and bank_mask[(L%16)/4] are both 1. Otherwise its write-enable is 0 and its result equals its old value.
- R8: For an eligible lane with an invalid source, bound_zero=1 writes zero with the write-enable set. bound_zero=0 leaves the write-enable at 0 and the result equal to the old value.
- R9: Any code with ctrl[8]=1 that is not listed in R2..R6 sets out_illegal for that result. All write-enables are then 0 and every result equals its old value.
- R10: Results, write-enables, out_valid and out_illegal appear on the clock edge after in_valid. When in_valid was low, out_valid, out_illegal and all write-enables are 0 and the result vector holds its last value.
- R11: After reset, out_valid, out_illegal, out_we and out_data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present this cycle |
| ctrl | input | 9 | Sharing pattern code |
| row_mask | input | 4 | Per-row enable, bit r for lanes 16r..16r+15 |
| bank_mask | input | 4 | Per-bank enable, bit b for lanes with (L%16)/4 = b |
| bound_zero | input | 1 | 1: invalid source reads as zero and is written |
| src_data | input | 2048 | Source values, lane L at bits 32L+31..32L |
| old_data | input | 2048 | Old destination values, same packing |
| out_valid | output | 1 | Result present |
| out_illegal | output | 1 | Result came from an undefined code |
| out_data | output | 2048 | Result values, same packing |
| out_we | output | 64 | Per-lane write-enable |

## Verification
The assertions assume that the request inputs are settled before each rising edge. They also assume that a masked row can never produce a write, whatever code is given. The stimulus changes inputs only on falling edges and holds them steady for a full cycle. It mixes legal codes with undefined codes, partial masks, both boundary settings and idle gaps, so every state transition occurs. The reference model in the bench uses new random source and old vectors for every request, so a wrong lane selection shows up as a data mismatch.

// File: rtl/wsu_pkg.sv
package wsu_pkg;
    typedef enum logic [3:0] {
        MD_QUAD, MD_RSHL, MD_RSHR, MD_RROR,
        MD_WSHL, MD_WROL, MD_WSHR, MD_WROR,
        MD_MIRROR, MD_HMIRROR, MD_BC_ROW, MD_BC_31, MD_BAD
    } mode_t;

    typedef enum logic [1:0] {
        ST_IDLE, ST_DONE, ST_FAULT
    } ostate_t;

    localparam int CTRL_W = 9;
endpackage

// File: rtl/wsu_decode.sv
module wsu_decode
    import wsu_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl,
    output mode_t             mode,
    output logic [3:0]        amount,
    output logic              legal
);
    logic [3:0] grp;
    logic [3:0] sub;

    always_comb begin
        grp    = ctrl[7:4];
        sub    = ctrl[3:0];
        mode   = MD_BAD;
        amount = sub;
        if (!ctrl[8]) begin
            mode = MD_QUAD;
        end else begin
            unique case (grp)
                4'h0: mode = (sub != 4'd0) ? MD_RSHL : MD_BAD;
                4'h1: mode = (sub != 4'd0) ? MD_RSHR : MD_BAD;
                4'h2: mode = (sub != 4'd0) ? MD_RROR : MD_BAD;
                4'h3: begin
                    unique case (sub)
                        4'h0:    mode = MD_WSHL;
                        4'h4:    mode = MD_WROL;
                        4'h8:    mode = MD_WSHR;
                        4'hC:    mode = MD_WROR;
                        default: mode = MD_BAD;
                    endcase
                end
                4'h4: begin
                    unique case (sub)
                        4'h0:    mode = MD_MIRROR;
                        4'h1:    mode = MD_HMIRROR;
                        4'h2:    mode = MD_BC_ROW;
                        4'h3:    mode = MD_BC_31;
                        default: mode = MD_BAD;
                    endcase
                end
                default: mode = MD_BAD;
            endcase
        end
        legal = (mode != MD_BAD);
    end
endmodule

// File: rtl/wsu_lane_route.sv
module wsu_lane_route
    import wsu_pkg::*;
#(
    parameter int LANE   = 0,
    parameter int LANES  = 64,
    parameter int ROWLEN = 16
) (
    input  mode_t                      mode,
    input  logic [3:0]                 amount,
    input  logic [7:0]                 qsel,
    output logic [$clog2(LANES)-1:0]   src,
    output logic                       src_ok
);
    localparam int IDXW = $clog2(LANES);
    localparam int POS  = LANE % ROWLEN;
    localparam int BASE = LANE - POS;
    localparam int QPOS = LANE % 4;
    localparam int HALF = ROWLEN / 2;

    int v;

    always_comb begin
        v      = LANE;
        src_ok = 1'b1;
        unique case (mode)
            MD_QUAD:    v = (LANE - QPOS) + int'(qsel[2*QPOS +: 2]);
            MD_RSHL: begin
                v      = LANE + int'(amount);
                src_ok = (POS + int'(amount)) < ROWLEN;
            end
            MD_RSHR: begin
                v      = LANE - int'(amount);
                src_ok = POS >= int'(amount);
            end
            MD_RROR:    v = BASE + ((POS - int'(amount) + ROWLEN) % ROWLEN);
            MD_WSHL: begin
                v      = (LANE + 1) % LANES;
                src_ok = (LANE != LANES - 1);
            end
            MD_WROL:    v = (LANE + 1) % LANES;
            MD_WSHR: begin
                v      = (LANE + LANES - 1) % LANES;
                src_ok = (LANE != 0);
            end
            MD_WROR:    v = (LANE + LANES - 1) % LANES;
            MD_MIRROR:  v = BASE + (ROWLEN - 1 - POS);
            MD_HMIRROR: v = (LANE - LANE % HALF) + (HALF - 1 - LANE % HALF);
            MD_BC_ROW: begin
                v      = (BASE == 0) ? LANE : BASE - 1;
                src_ok = (BASE != 0);
            end
            MD_BC_31: begin
                v      = 2 * ROWLEN - 1;
                src_ok = (BASE >= 2 * ROWLEN);
            end
            default:    src_ok = 1'b0;
        endcase
        src = IDXW'(v);
    end
endmodule

// File: rtl/wave_share_unit.sv
module wave_share_unit
    import wsu_pkg::*;
#(
    parameter int LANES   = 64,
    parameter int ROWLEN  = 16,
    parameter int BANKLEN = 4,
    parameter int DW      = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [CTRL_W-1:0]     ctrl,
    input  logic [3:0]            row_mask,
    input  logic [3:0]            bank_mask,
    input  logic                  bound_zero,
    input  logic [LANES*DW-1:0]   src_data,
    input  logic [LANES*DW-1:0]   old_data,
    output logic                  out_valid,
    output logic                  out_illegal,
    output logic [LANES*DW-1:0]   out_data,
    output logic [LANES-1:0]      out_we
);
    localparam int IDXW  = $clog2(LANES);
    localparam int NROWS = LANES / ROWLEN;

    mode_t           mode;
    logic [3:0]      amount;
    logic            legal;
    ostate_t         state, state_nx;
    logic [LANES-1:0]    we_nx;
    logic [LANES*DW-1:0] data_nx;

    wsu_decode u_dec (
        .ctrl   (ctrl),
        .mode   (mode),
        .amount (amount),
        .legal  (legal)
    );

    for (genvar L = 0; L < LANES; L++) begin : g_lane
        logic [IDXW-1:0] src;
        logic            ok;
        logic            elig;

        wsu_lane_route #(.LANE(L), .LANES(LANES), .ROWLEN(ROWLEN)) u_route (
            .mode   (mode),
            .amount (amount),
            .qsel   (ctrl[7:0]),
            .src    (src),
            .src_ok (ok)
        );

        assign elig = legal && row_mask[L / ROWLEN] && bank_mask[(L % ROWLEN) / BANKLEN];
        assign we_nx[L] = elig && (ok || bound_zero);
        assign data_nx[L*DW +: DW] = !we_nx[L] ? old_data[L*DW +: DW]
                                   : ok ? src_data[int'(src)*DW +: DW]
                                   : '0;
    end

    // next-state selection
    always_comb begin
        state_nx = ST_IDLE;
        if (in_valid) state_nx = legal ? ST_DONE : ST_FAULT;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_we   <= '0;
            out_data <= '0;
        end else begin
            unique case (state_nx)
                ST_DONE: begin
                    out_we   <= we_nx;
                    out_data <= data_nx;
                end
                ST_FAULT: begin
                    out_we   <= '0;
                    out_data <= old_data;
                end
                default: out_we <= '0;
            endcase
        end
    end

    assign out_valid   = (state != ST_IDLE);
    assign out_illegal = (state == ST_FAULT);

    AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_we == '0));                                   // R9
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_we == '0));                                    // R10
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                           // R10
    AST_QUIET_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                         // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));                                  // R10

    for (genvar g = 0; g < NROWS; g++) begin : g_rowchk
        AST_ROW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !row_mask[g]) |=> (out_we[g*ROWLEN +: ROWLEN] == '0)); // R7
    end
endmodule

// File: tb/wave_share_unit_test.sv
module wave_share_unit_test;
    localparam int LANES = 64;
    localparam int DW    = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [8:0] ctrl = '0;
    logic [3:0] row_mask = 4'hF;
    logic [3:0] bank_mask = 4'hF;
    logic bound_zero = 1'b0;
    logic [LANES*DW-1:0] src_data = '0;
    logic [LANES*DW-1:0] old_data = '0;
    logic out_valid, out_illegal;
    logic [LANES*DW-1:0] out_data;
    logic [LANES-1:0] out_we;

    always #5 clk = ~clk;

    wave_share_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ctrl(ctrl),
        .row_mask(row_mask), .bank_mask(bank_mask), .bound_zero(bound_zero),
        .src_data(src_data), .old_data(old_data), .out_valid(out_valid),
        .out_illegal(out_illegal), .out_data(out_data), .out_we(out_we)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [DW-1:0] exp_data [LANES];
    logic [LANES-1:0] exp_we;
    logic exp_valid, exp_ill;
    string exp_tag;

    // behavioural source lookup: returns -1 for undefined code, -2 for no source
    function automatic int ref_src(int code, int lane);
        int row = lane / 16, pos = lane % 16, n = code % 16;
        if (code < 256) return (lane / 4) * 4 + ((code >> (2 * (lane % 4))) % 4);
        if (code > 256 && code < 272) return (pos + n <= 15) ? lane + n : -2;
        if (code > 272 && code < 288) return (pos - n >= 0) ? lane - n : -2;
        if (code > 288 && code < 304) return row * 16 + ((pos - n + 16) % 16);
        if (code == 'h130) return (lane == 63) ? -2 : lane + 1;
        if (code == 'h134) return (lane + 1) % 64;
        if (code == 'h138) return (lane == 0) ? -2 : lane - 1;
        if (code == 'h13C) return (lane + 63) % 64;
        if (code == 'h140) return row * 16 + 15 - pos;
        if (code == 'h141) return (lane / 8) * 8 + 7 - lane % 8;
        if (code == 'h142) return (row == 0) ? -2 : row * 16 - 1;
        if (code == 'h143) return (row < 2) ? -2 : 31;
        return -1;
    endfunction

    task automatic compare();
        bit bad = 0;
        checks++;
        if (out_valid !== exp_valid || out_illegal !== exp_ill || out_we !== exp_we) begin
            errors++;
            $display("FAIL %s status: valid=%0b ill=%0b we=%h expected valid=%0b ill=%0b we=%h",
                     exp_tag, out_valid, out_illegal, out_we, exp_valid, exp_ill, exp_we);
        end
        checks++;
        for (int l = 0; l < LANES; l++) begin
            if (!bad && out_data[l*DW +: DW] !== exp_data[l]) begin
                bad = 1;
                errors++;
                $display("FAIL %s data lane %0d: got %h expected %h",
                         exp_tag, l, out_data[l*DW +: DW], exp_data[l]);
            end
        end
    endtask

    task automatic step(bit v, int code, int rm, int bm, bit bz, string tag);
        @(negedge clk);
        compare();
        in_valid = v; ctrl = 9'(code); row_mask = 4'(rm); bank_mask = 4'(bm); bound_zero = bz;
        for (int l = 0; l < LANES; l++) begin
            src_data[l*DW +: DW] = $urandom;
            old_data[l*DW +: DW] = $urandom;
        end
        exp_tag = tag;
        exp_valid = v;
        exp_ill = 0;
        exp_we = '0;
        if (v) begin
            for (int l = 0; l < LANES; l++) begin
                int s = ref_src(code, l);
                bit en = ((rm >> (l / 16)) & 1) == 1 && ((bm >> ((l % 16) / 4)) & 1) == 1;
                exp_data[l] = old_data[l*DW +: DW];
                if (s == -1) exp_ill = 1;
                else if (en && s >= 0) begin
                    exp_we[l] = 1'b1; exp_data[l] = src_data[s*DW +: DW];
                end else if (en && bz) begin
                    exp_we[l] = 1'b1; exp_data[l] = '0;
                end
            end
        end
    endtask

    initial begin
        #1500000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        exp_valid = 0; exp_ill = 0; exp_we = '0; exp_tag = "R11 reset";
        for (int l = 0; l < LANES; l++) exp_data[l] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(1, 'h1B, 15, 15, 0, "R1 quad reverse");
        step(1, 'hE4, 15, 15, 0, "R1 quad identity");
        step(1, 'h55, 15, 15, 1, "R1 quad splat");
        step(1, 'h101, 15, 15, 0, "R2 shl1 hold");
        step(1, 'h10F, 15, 15, 1, "R2 shl15 zero");
        step(1, 'h113, 15, 15, 0, "R2 shr3");
        step(1, 'h11F, 15, 15, 1, "R2 shr15");
        step(1, 'h125, 15, 15, 0, "R3 ror5");
        step(1, 'h12F, 15, 15, 0, "R3 ror15");
        step(1, 'h130, 15, 15, 0, "R4 wave shl");
        step(1, 'h134, 15, 15, 0, "R4 wave rol");
        step(1, 'h138, 15, 15, 1, "R4 wave shr");
        step(1, 'h13C, 15, 15, 0, "R4 wave ror");
        step(1, 'h140, 15, 15, 0, "R5 mirror");
        step(1, 'h141, 15, 15, 0, "R5 half mirror");
        step(1, 'h142, 15, 15, 0, "R6 bcast row");
        step(1, 'h142, 15, 15, 1, "R6 bcast row zero");
        step(1, 'h143, 15, 15, 0, "R6 bcast 31");
        step(1, 'h143, 15, 15, 1, "R6 bcast 31 zero");
        step(1, 'h1B, 5, 15, 0, "R7 row mask");
        step(1, 'h140, 15, 9, 0, "R7 bank mask");
        step(1, 'h113, 6, 10, 1, "R7 R8 masks with zero");
        step(1, 'h101, 0, 15, 1, "R7 all rows off");
        step(0, 0, 15, 15, 0, "R10 idle gap");
        step(1, 'h100, 15, 15, 0, "R9 illegal shift0");
        step(1, 'h131, 15, 15, 1, "R9 illegal wave");
        step(1, 'h1FF, 15, 15, 0, "R9 illegal top");
        step(1, 'h144, 15, 15, 0, "R9 illegal after bcast");
        step(1, 'h120, 15, 15, 0, "R9 illegal ror0");
        step(0, 0, 15, 15, 0, "R10 idle after fault");
        step(0, 0, 15, 15, 0, "R10 idle twice");
        for (int k = 0; k < 40; k++)
            step(1, 256 + ($urandom % 80), $urandom % 16, $urandom % 16, 1'($urandom), "R8 mixed");
        step(1, 'h10A, 15, 15, 0, "R8 final");
        step(0, 0, 15, 15, 0, "R10 drain");
        @(negedge clk);
        compare();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule